// File: doc/BRIEF.md
# Dual-Clock Burst-Aware FIFO

This block carries words from a producer clock domain to a consumer clock domain whose clock has no fixed relation to the producer's. Each stored entry bundles a 32-bit address/data word, a 4-bit byte-enable field and a 4-bit phase tag. The tag says whether the entry is the address phase of a burst, an ordinary data phase, or the final data phase. The producer sees full and almost-full flags in its own clock domain. The consumer sees empty and almost-empty flags in its own clock domain.

Beyond plain FIFO ordering, the block counts how many final-tagged entries have been written and how many have been read. It raises a burst-ready flag on the consumer side while at least one complete burst is stored, so a consumer can wait for a whole transfer before it starts to drain. A one-cycle flush on the consumer side throws away everything the consumer can see. An asynchronous reset clears both domains.

Top module: `xclk_burst_fifo`

## Requirements
- R1: Each entry keeps its data, byte-enable and tag fields together, and entries leave in the order they were written.
- R2: A write is stored at the rising write-clock edge where wr_en is high and wr_full is low. At a rising read-clock edge where rd_en is high, rd_empty is low and rd_flush is low, the head entry moves onto rd_data/rd_be/rd_tag just after that edge. Those outputs hold their value at every other edge.
- R3: Tag encodings are 4'h1 for the address phase, 4'h2 for a data phase and 4'h4 for the final phase. Only 4'h4 ends a burst.
- R4: On the write side, with no reads in progress, wr_afull is high exactly when DEPTH-1 entries are stored and wr_full is high exactly when DEPTH entries are stored. wr_full never rises without wr_afull high in the cycle before.
- R5: On the read side, once writes have crossed over, rd_aempty is high exactly when one entry is visible and rd_empty is high exactly when none is. Outside a flush, rd_empty never rises without rd_aempty high in the cycle before.
- R6: rd_burst_rdy is high while the read side sees more final-tagged entries written than read, and low otherwise. A burst made of a single final-tagged entry counts, and rd_burst_rdy is never high while rd_empty is high.
- R7: A write while wr_full is high is dropped: the write pointer does not move and the word never appears at the read port.
- R8: A read while rd_empty is high is ignored: the read pointer and the read outputs do not change, and the next entry written is the next entry read.
- R9: A one-cycle rd_flush discards every entry visible to the read side. It leaves rd_empty high and rd_burst_rdy low after the edge, takes priority over a read in the same cycle, and the write side regains its space once the flush has crossed over.
- R10: While rst_n is low, both domains are empty: rd_empty high, rd_aempty, wr_full, wr_afull and rd_burst_rdy low, and the read outputs zero.
- R11: Pointers cross domains in Gray code, changing at most one bit per clock. Ordering and flags are correct whether the read clock is slower or faster than the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Address/data word to store |
| wr_be | input | BEW | Byte enables to store |
| wr_tag | input | 4 | Phase tag to store |
| wr_full | output | 1 | No free slot as seen by the writer |
| wr_afull | output | 1 | Exactly one free slot as seen by the writer |
| rd_en | input | 1 | Read request |
| rd_flush | input | 1 | Discard all entries visible to the reader |
| rd_data | output | DW | Address/data word of the last entry read |
| rd_be | output | BEW | Byte enables of the last entry read |
| rd_tag | output | 4 | Phase tag of the last entry read |
| rd_empty | output | 1 | No entry visible to the reader |
| rd_aempty | output | 1 | Exactly one entry visible to the reader |
| rd_burst_rdy | output | 1 | At least one complete burst is stored |

## Verification
The bench builds the block with DEPTH 4 and a 2-bit address, so every fill level from empty to full is reached directly and both flags on each side switch within a handful of writes. The 3-bit pointers wrap several times during the streaming pass. The same sequence of fill, overflow, underflow, burst counting and flush runs twice: first with a read clock slower than the 100 MHz write clock, then with a faster one. Both clock orderings are therefore covered with the same expected values.

// File: rtl/xbf_pkg.sv
`timescale 1ns/1ps
package xbf_pkg;
   localparam int TAG_W = 4;
   localparam logic [TAG_W-1:0] TAG_ADDR = 4'h1;
   localparam logic [TAG_W-1:0] TAG_DATA = 4'h2;
   localparam logic [TAG_W-1:0] TAG_LAST = 4'h4;
endpackage

// File: rtl/xbf_g2b.sv
`timescale 1ns/1ps
// Gray to binary conversion: each binary bit is the XOR of all Gray bits at or above it.
module xbf_g2b #(
   parameter int W = 5
) (
   input  logic [W-1:0] g,
   output logic [W-1:0] b
);
   always_comb begin
      for (int i = 0; i < W; i++) begin
         b[i] = ^(g >> i);
      end
   end
endmodule

// File: rtl/xbf_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a Gray-coded bus.
module xbf_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_gray,
   output logic [W-1:0] q_gray
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xbf_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d_gray;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q_gray = chain[STAGES-1];
endmodule

// File: rtl/xbf_ptr_cnt.sv
`timescale 1ns/1ps
// Binary counter with a registered Gray copy and a load from a Gray value.
module xbf_ptr_cnt #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         load,
   input  logic [W-1:0] load_gray,
   output logic [W-1:0] bin_q,
   output logic [W-1:0] gray_q
);
   logic [W-1:0] load_bin;
   logic [W-1:0] bin_d;

   xbf_g2b #(.W(W)) u_load_g2b (
      .g (load_gray),
      .b (load_bin)
   );

   always_comb begin
      bin_d = bin_q;
      if (load) begin
         bin_d = load_bin;
      end else if (inc) begin
         bin_d = bin_q + W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else begin
         bin_q  <= bin_d;
         gray_q <= bin_d ^ (bin_d >> 1);
      end
   end
endmodule

// File: rtl/xbf_store.sv
`timescale 1ns/1ps
// Entry storage: written in the write domain, head registered out in the read domain.
module xbf_store #(
   parameter int AW    = 4,
   parameter int DEPTH = 16,
   parameter int EW    = 40,
   parameter int TW    = 4
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [EW-1:0] wdata,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [TW-1:0] head_tag,
   output logic [EW-1:0] q
);
   logic [EW-1:0] cells [DEPTH];
   logic [EW-1:0] head;

   always_ff @(posedge wr_clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign head     = cells[raddr];
   assign head_tag = head[TW-1:0];

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (re) begin
         q <= head;
      end
   end
endmodule

// File: rtl/xbf_wr_side.sv
`timescale 1ns/1ps
// Write domain: pointer, final-phase counter, full flags.
module xbf_wr_side
   import xbf_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [AW:0]      rptr_gray_x,
   output logic [AW-1:0]    waddr,
   output logic [AW:0]      wptr_gray,
   output logic [AW:0]      wlast_gray,
   output logic             full,
   output logic             afull,
   output logic             wr_fire
);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] FULL_LVL  = PW'(DEPTH);
   localparam logic [PW-1:0] AFULL_LVL = PW'(DEPTH - 1);

   logic [PW-1:0] rsync_gray;
   logic [PW-1:0] rsync_bin;
   logic [PW-1:0] wptr_bin;
   logic [PW-1:0] fill;
   logic [PW-1:0] wlast_bin_unused;
   logic          last_fire;

   xbf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
      .clk    (wr_clk),
      .rst_n  (rst_n),
      .d_gray (rptr_gray_x),
      .q_gray (rsync_gray)
   );

   xbf_g2b #(.W(PW)) u_rptr_g2b (
      .g (rsync_gray),
      .b (rsync_bin)
   );

   assign fill      = wptr_bin - rsync_bin;
   assign full      = (fill == FULL_LVL);
   assign afull     = (fill == AFULL_LVL);
   assign wr_fire   = wr_en & ~full;
   assign last_fire = wr_fire & (wr_tag == TAG_LAST);
   assign waddr     = wptr_bin[AW-1:0];

   xbf_ptr_cnt #(.W(PW)) u_wptr (
      .clk       (wr_clk),
      .rst_n     (rst_n),
      .inc       (wr_fire),
      .load      (1'b0),
      .load_gray ({PW{1'b0}}),
      .bin_q     (wptr_bin),
      .gray_q    (wptr_gray)
   );

   xbf_ptr_cnt #(.W(PW)) u_wlast (
      .clk       (wr_clk),
      .rst_n     (rst_n),
      .inc       (last_fire),
      .load      (1'b0),
      .load_gray ({PW{1'b0}}),
      .bin_q     (wlast_bin_unused),
      .gray_q    (wlast_gray)
   );
endmodule

// File: rtl/xbf_rd_side.sv
`timescale 1ns/1ps
// Read domain: pointer, final-phase counter, empty flags, burst-ready, flush.
module xbf_rd_side
   import xbf_pkg::*;
#(
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             flush,
   input  logic [TAG_W-1:0] head_tag,
   input  logic [AW:0]      wptr_gray_x,
   input  logic [AW:0]      wlast_gray_x,
   output logic [AW-1:0]    raddr,
   output logic [AW:0]      rptr_gray,
   output logic [AW:0]      wsync_gray,
   output logic             empty,
   output logic             aempty,
   output logic             rd_fire,
   output logic             burst_rdy
);
   localparam int PW = AW + 1;

   logic [PW-1:0] wsync_bin;
   logic [PW-1:0] lsync_gray;
   logic [PW-1:0] lsync_bin;
   logic [PW-1:0] rptr_bin;
   logic [PW-1:0] rlast_bin;
   logic [PW-1:0] rlast_gray_unused;
   logic [PW-1:0] level;
   logic          last_fire;

   xbf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
      .clk    (rd_clk),
      .rst_n  (rst_n),
      .d_gray (wptr_gray_x),
      .q_gray (wsync_gray)
   );

   xbf_g2b #(.W(PW)) u_wptr_g2b (
      .g (wsync_gray),
      .b (wsync_bin)
   );

   xbf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wlast_sync (
      .clk    (rd_clk),
      .rst_n  (rst_n),
      .d_gray (wlast_gray_x),
      .q_gray (lsync_gray)
   );

   xbf_g2b #(.W(PW)) u_wlast_g2b (
      .g (lsync_gray),
      .b (lsync_bin)
   );

   assign level     = wsync_bin - rptr_bin;
   assign empty     = (level == '0);
   assign aempty    = (level == PW'(1));
   assign rd_fire   = rd_en & ~empty & ~flush;
   assign last_fire = rd_fire & (head_tag == TAG_LAST);
   assign raddr     = rptr_bin[AW-1:0];
   assign burst_rdy = (lsync_bin != rlast_bin);

   xbf_ptr_cnt #(.W(PW)) u_rptr (
      .clk       (rd_clk),
      .rst_n     (rst_n),
      .inc       (rd_fire),
      .load      (flush),
      .load_gray (wsync_gray),
      .bin_q     (rptr_bin),
      .gray_q    (rptr_gray)
   );

   xbf_ptr_cnt #(.W(PW)) u_rlast (
      .clk       (rd_clk),
      .rst_n     (rst_n),
      .inc       (last_fire),
      .load      (flush),
      .load_gray (lsync_gray),
      .bin_q     (rlast_bin),
      .gray_q    (rlast_gray_unused)
   );
endmodule

// File: rtl/xclk_burst_fifo.sv
`timescale 1ns/1ps
module xclk_burst_fifo
   import xbf_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DEPTH       = 16,
   parameter int DW          = 32,
   parameter int BEW         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DW-1:0]    wr_data,
   input  logic [BEW-1:0]   wr_be,
   input  logic [TAG_W-1:0] wr_tag,
   output logic             wr_full,
   output logic             wr_afull,
   input  logic             rd_en,
   input  logic             rd_flush,
   output logic [DW-1:0]    rd_data,
   output logic [BEW-1:0]   rd_be,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_empty,
   output logic             rd_aempty,
   output logic             rd_burst_rdy
);
   localparam int PW = AW + 1;
   localparam int EW = DW + BEW + TAG_W;

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("DEPTH must equal 2**AW");
      end
      if (DEPTH < 4) begin : g_bad_small
         $error("DEPTH must be at least 4");
      end
   endgenerate

   logic [AW-1:0]    waddr;
   logic [AW-1:0]    raddr;
   logic [PW-1:0]    wptr_gray;
   logic [PW-1:0]    wlast_gray;
   logic [PW-1:0]    rptr_gray;
   logic [PW-1:0]    wsync_gray;
   logic             wr_fire;
   logic             rd_fire;
   logic [TAG_W-1:0] head_tag;
   logic [EW-1:0]    q;

   xbf_wr_side #(.AW(AW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_wr (
      .wr_clk      (wr_clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_tag      (wr_tag),
      .rptr_gray_x (rptr_gray),
      .waddr       (waddr),
      .wptr_gray   (wptr_gray),
      .wlast_gray  (wlast_gray),
      .full        (wr_full),
      .afull       (wr_afull),
      .wr_fire     (wr_fire)
   );

   xbf_store #(.AW(AW), .DEPTH(DEPTH), .EW(EW), .TW(TAG_W)) u_store (
      .wr_clk   (wr_clk),
      .we       (wr_fire),
      .waddr    (waddr),
      .wdata    ({wr_data, wr_be, wr_tag}),
      .rd_clk   (rd_clk),
      .rst_n    (rst_n),
      .re       (rd_fire),
      .raddr    (raddr),
      .head_tag (head_tag),
      .q        (q)
   );

   xbf_rd_side #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_rd (
      .rd_clk       (rd_clk),
      .rst_n        (rst_n),
      .rd_en        (rd_en),
      .flush        (rd_flush),
      .head_tag     (head_tag),
      .wptr_gray_x  (wptr_gray),
      .wlast_gray_x (wlast_gray),
      .raddr        (raddr),
      .rptr_gray    (rptr_gray),
      .wsync_gray   (wsync_gray),
      .empty        (rd_empty),
      .aempty       (rd_aempty),
      .rd_fire      (rd_fire),
      .burst_rdy    (rd_burst_rdy)
   );

   assign rd_data = q[EW-1 -: DW];
   assign rd_be   = q[TAG_W +: BEW];
   assign rd_tag  = q[TAG_W-1:0];
endmodule

// File: rtl/xbf_chk.sv
`timescale 1ns/1ps
module xbf_chk #(
   parameter int PW = 5,
   parameter int DW = 32
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          rd_en,
   input logic          rd_flush,
   input logic          wr_full,
   input logic          wr_afull,
   input logic          rd_empty,
   input logic          rd_aempty,
   input logic          rd_burst_rdy,
   input logic [DW-1:0] rd_data,
   input logic [PW-1:0] wptr_gray,
   input logic [PW-1:0] rptr_gray,
   input logic [PW-1:0] wsync_gray
);
   AST_FULL_AFTER_AFULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $rose(wr_full) |-> $past(wr_afull)); // R4

   AST_EMPTY_AFTER_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
      ($rose(rd_empty) && !$past(rd_flush)) |-> $past(rd_aempty)); // R5

   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_full && wr_en) |=> $stable(wptr_gray)); // R7

   AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_empty && rd_en && !rd_flush) |=> ($stable(rptr_gray) && $stable(rd_data))); // R8

   AST_FLUSH_DRAINS: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_flush |=> (rptr_gray == $past(wsync_gray))); // R9

   AST_BURST_NOT_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_burst_rdy |-> !rd_empty); // R6

   AST_WPTR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $countones(wptr_gray ^ $past(wptr_gray)) <= 1); // R11

   AST_RPTR_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !$past(rd_flush) |-> ($countones(rptr_gray ^ $past(rptr_gray)) <= 1)); // R11
endmodule

bind xclk_burst_fifo xbf_chk #(.PW(AW + 1), .DW(DW)) u_xbf_chk (
   .wr_clk       (wr_clk),
   .rd_clk       (rd_clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .rd_flush     (rd_flush),
   .wr_full      (wr_full),
   .wr_afull     (wr_afull),
   .rd_empty     (rd_empty),
   .rd_aempty    (rd_aempty),
   .rd_burst_rdy (rd_burst_rdy),
   .rd_data      (rd_data),
   .wptr_gray    (wptr_gray),
   .rptr_gray    (rptr_gray),
   .wsync_gray   (wsync_gray)
);

// File: tb/test_xclk_burst_fifo.sv
`timescale 1ns/1ps
module test_xclk_burst_fifo;
   localparam int AW    = 2;
   localparam int DEPTH = 4;
   localparam logic [3:0] T_ADDR = 4'h1;
   localparam logic [3:0] T_DATA = 4'h2;
   localparam logic [3:0] T_LAST = 4'h4;
   localparam int NSTREAM = 24;

   logic        wr_clk = 1'b0;
   logic        rd_clk = 1'b0;
   logic        rst_n  = 1'b0;
   logic        wr_en  = 1'b0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_be   = '0;
   logic [3:0]  wr_tag  = '0;
   logic        wr_full, wr_afull;
   logic        rd_en    = 1'b0;
   logic        rd_flush = 1'b0;
   logic [31:0] rd_data;
   logic [3:0]  rd_be, rd_tag;
   logic        rd_empty, rd_aempty, rd_burst_rdy;

   int n_chk  = 0;
   int n_fail = 0;
   int rd_half = 14;
   bit done = 1'b0;

   always #5 wr_clk = ~wr_clk;
   always #(rd_half) rd_clk = ~rd_clk;

   xclk_burst_fifo #(.AW(AW), .DEPTH(DEPTH), .DW(32), .BEW(4), .SYNC_STAGES(2)) i_xclk_burst_fifo (
      .wr_clk       (wr_clk),
      .rd_clk       (rd_clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .wr_be        (wr_be),
      .wr_tag       (wr_tag),
      .wr_full      (wr_full),
      .wr_afull     (wr_afull),
      .rd_en        (rd_en),
      .rd_flush     (rd_flush),
      .rd_data      (rd_data),
      .rd_be        (rd_be),
      .rd_tag       (rd_tag),
      .rd_empty     (rd_empty),
      .rd_aempty    (rd_aempty),
      .rd_burst_rdy (rd_burst_rdy)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_entry(input string req, input logic [31:0] d, input logic [3:0] b, input logic [3:0] t);
      chk(req, "rd_data", 64'(rd_data), 64'(d));
      chk(req, "rd_be", 64'(rd_be), 64'(b));
      chk(req, "rd_tag", 64'(rd_tag), 64'(t));
   endtask

   task automatic push(input logic [31:0] d, input logic [3:0] b, input logic [3:0] t);
      @(negedge wr_clk);
      wr_en = 1'b1; wr_data = d; wr_be = b; wr_tag = t;
      @(negedge wr_clk);
      wr_en = 1'b0;
   endtask

   task automatic pop();
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge rd_clk);
      repeat (4) @(negedge wr_clk);
      repeat (4) @(negedge rd_clk);
   endtask

   function automatic logic [3:0] fill_tag(input int k);
      if (k == DEPTH - 1) return T_LAST;
      if (k == 0) return T_ADDR;
      return T_DATA;
   endfunction

   function automatic logic [3:0] stream_tag(input int k);
      if (k % 4 == 3) return T_LAST;
      if (k % 4 == 0) return T_ADDR;
      return T_DATA;
   endfunction

   task automatic run_phase(input int p);
      logic [31:0] base;
      base = 32'(p + 1) << 28;
      settle();
      // fill from empty, R4 flags after each write, R6 before the final phase arrives
      for (int k = 0; k < DEPTH; k++) begin
         push(base + 32'(k), 4'(k), fill_tag(k));
         chk("R4", "wr_afull", 64'(wr_afull), 64'(k + 1 == DEPTH - 1));
         chk("R4", "wr_full", 64'(wr_full), 64'(k + 1 == DEPTH));
         if (k == DEPTH - 2) begin
            settle();
            chk("R6", "burst_rdy before final", 64'(rd_burst_rdy), 64'd0);
            chk("R5", "empty partly filled", 64'(rd_empty), 64'd0);
         end
      end
      // write while full is dropped (R7)
      push(32'hDEAD_BEEF, 4'hF, T_LAST);
      chk("R7", "wr_full after drop", 64'(wr_full), 64'd1);
      settle();
      chk("R6", "burst_rdy full", 64'(rd_burst_rdy), 64'd1);
      chk("R5", "aempty full", 64'(rd_aempty), 64'd0);
      // drain in order (R1, R2, R5, R6)
      for (int k = 0; k < DEPTH; k++) begin
         pop();
         chk_entry("R1", base + 32'(k), 4'(k), fill_tag(k));
         chk("R5", "aempty drain", 64'(rd_aempty), 64'(DEPTH - 1 - k == 1));
         chk("R5", "empty drain", 64'(rd_empty), 64'(k == DEPTH - 1));
         chk("R6", "burst_rdy drain", 64'(rd_burst_rdy), 64'(k < DEPTH - 1));
      end
      // read while empty is ignored (R8), overflow word never shows (R7)
      pop();
      chk_entry("R8", base + 32'(DEPTH - 1), 4'(DEPTH - 1), T_LAST);
      settle();
      chk("R7", "dropped word absent", 64'(rd_empty), 64'd1);
      chk("R4", "wr_full after drain", 64'(wr_full), 64'd0);
      chk("R4", "wr_afull after drain", 64'(wr_afull), 64'd0);
      // single-entry burst (R6, R8, R3)
      push(base + 32'h100, 4'hF, T_LAST);
      settle();
      chk("R6", "single burst ready", 64'(rd_burst_rdy), 64'd1);
      chk("R5", "aempty one entry", 64'(rd_aempty), 64'd1);
      pop();
      chk_entry("R8", base + 32'h100, 4'hF, T_LAST);
      chk("R6", "single burst consumed", 64'(rd_burst_rdy), 64'd0);
      // two bursts counted separately (R6, R3)
      push(base + 32'h200, 4'h3, T_ADDR);
      push(base + 32'h201, 4'h5, T_LAST);
      push(base + 32'h202, 4'h6, T_LAST);
      settle();
      chk("R6", "two bursts", 64'(rd_burst_rdy), 64'd1);
      pop();
      pop();
      chk_entry("R3", base + 32'h201, 4'h5, T_LAST);
      chk("R6", "second burst pending", 64'(rd_burst_rdy), 64'd1);
      pop();
      chk("R6", "both bursts consumed", 64'(rd_burst_rdy), 64'd0);
      // flush with a read in the same cycle (R9)
      push(base + 32'h300, 4'h1, T_ADDR);
      push(base + 32'h301, 4'h2, T_DATA);
      push(base + 32'h302, 4'h3, T_LAST);
      settle();
      chk("R9", "burst before flush", 64'(rd_burst_rdy), 64'd1);
      @(negedge rd_clk);
      rd_flush = 1'b1; rd_en = 1'b1;
      @(negedge rd_clk);
      rd_flush = 1'b0; rd_en = 1'b0;
      chk("R9", "empty after flush", 64'(rd_empty), 64'd1);
      chk("R9", "burst after flush", 64'(rd_burst_rdy), 64'd0);
      chk_entry("R9", base + 32'h202, 4'h6, T_LAST);
      settle();
      chk("R9", "writer space full", 64'(wr_full), 64'd0);
      chk("R9", "writer space afull", 64'(wr_afull), 64'd0);
      push(base + 32'h400, 4'h9, T_LAST);
      settle();
      chk("R9", "new entry visible", 64'(rd_empty), 64'd0);
      pop();
      chk_entry("R9", base + 32'h400, 4'h9, T_LAST);
      // streaming with concurrent writer and reader (R1, R11)
      fork
         begin
            for (int k = 0; k < NSTREAM; k++) begin
               @(negedge wr_clk);
               while (wr_full) @(negedge wr_clk);
               wr_en = 1'b1; wr_data = base + 32'h1000 + 32'(k); wr_be = 4'(k); wr_tag = stream_tag(k);
               @(negedge wr_clk);
               wr_en = 1'b0;
            end
         end
         begin
            for (int k = 0; k < NSTREAM; k++) begin
               @(negedge rd_clk);
               while (rd_empty) @(negedge rd_clk);
               rd_en = 1'b1;
               @(negedge rd_clk);
               rd_en = 1'b0;
               chk_entry("R11", base + 32'h1000 + 32'(k), 4'(k), stream_tag(k));
            end
         end
      join
      settle();
      chk("R11", "empty after stream", 64'(rd_empty), 64'd1);
      chk("R6", "no burst after stream", 64'(rd_burst_rdy), 64'd0);
   endtask

   initial begin
      #23;
      chk("R10", "empty in reset", 64'(rd_empty), 64'd1);
      chk("R10", "full in reset", 64'(wr_full), 64'd0);
      rst_n = 1'b1;
      @(negedge wr_clk);
      chk("R10", "rd_empty", 64'(rd_empty), 64'd1);
      chk("R10", "rd_aempty", 64'(rd_aempty), 64'd0);
      chk("R10", "wr_full", 64'(wr_full), 64'd0);
      chk("R10", "wr_afull", 64'(wr_afull), 64'd0);
      chk("R10", "rd_burst_rdy", 64'(rd_burst_rdy), 64'd0);
      chk("R10", "rd_data", 64'(rd_data), 64'd0);
      rd_half = 14;
      run_phase(0);
      rd_half = 3;
      run_phase(1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #3ms;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule